// File: doc/BRIEF.md
# Mode-Aware Current Estimator Switch Controller

This block drives the eight analog routing switches of an LED current estimator in a buck, buck-boost or boost converter. Each switch connects the output of a high-side current sensor, a low-side current sensor, or a matched dummy branch to a sense resistor or to an auxiliary path. The controller chooses, cycle by cycle, which sensor output reaches the resistor. It does this so that, after filtering, the resistor voltage tracks the average load current in every operating mode.

When the boost-side device is switching, the path to the resistor is gated so that it is closed only while that device is off. This multiplies the sensed inductor current by one minus the boost duty. When the buck drive rises, the high-side sense amplifier needs some time to slew. During that time the low-side sensor's held value stays on the resistor and the high-side output is sent to its dummy branch. The slewing window lasts a programmable number of clock cycles, with a default of 4. It ends early if the amplifier reports that it has settled.

Top module: `est_switch_ctrl`

## Requirements
- R1: While reset is asserted, all eight switch enables are 0 (all switches open). Bit `swEn[i]` drives switch S(i+1).
- R2: Every switch output is registered. Inputs sampled at a clock edge take effect on the outputs at that same edge.
- R3: The high-side sensor is routed (S3 closed) when the buck drive is 1, the high-side sense phase is 1, and no slewing window is active.
- R4: The low-side sensor is routed (S2 closed) when the buck drive is 0, or when a slewing window is active.
- R5: S7 closes exactly when one sensor is routed and the gate is open. The gate is always open in buck mode (`opMode`=0). In buck-boost (`opMode`=1) and boost (`opMode`=2) it is open only while the boost drive is 0. In buck mode the boost drive has no effect.
- R6: S6 closes when a sensor is routed but the gate is shut, so the gated current still has a path.
- R7: A rising buck drive opens a slewing window. The window covers the edge at which the rise is first seen, plus the following edges, for a total of `slewLen` cycles. Values below 1 count as 1. During the window, S4 and S8 are both closed.
- R8: S1 and S5 are both closed exactly when the low-side sensor is not routed.
- R9: No sensor output is ever connected to both the resistor and its dummy branch: S3 and S4 are never both closed, and S2 and S1 are never both closed.
- R10: The slewing window length resets to 4. A pulse on `slewLoad` replaces it with `slewLenIn` from the next edge onwards.
- R11: When `hsSettled` is 1 during a slewing window, that cycle and all later cycles are treated as not slewing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock |
| rstN | input | 1 | Active-low synchronous reset |
| opMode | input | 2 | 0 buck, 1 buck-boost, 2 boost |
| buckDrv | input | 1 | Buck high-side drive (1 = high-side device on) |
| boostDrv | input | 1 | Boost low-side drive (1 = boost switch on) |
| hsSense | input | 1 | High-side sensor sense phase |
| hsSettled | input | 1 | High-side amplifier has settled |
| slewLoad | input | 1 | Load strobe for the slewing length |
| slewLenIn | input | 4 | New slewing length in cycles |
| swEn | output | 8 | Switch enables, bit i drives S(i+1) |

## Verification
The assertions assume that `opMode` is never 3. They also assume that in boost mode the buck drive stays high, so no slewing window opens there. The bench respects both rules: it only drives the three legal mode codes, and in its boost scenario it raises the buck drive before it switches the mode. The mode and the drive signals always change together at the falling clock edge, so every registered decision sees a single, coherent set of inputs.

// File: rtl/est_switch_pkg.sv
package est_switch_pkg;
  typedef enum logic [1:0] {
    MODE_BUCK  = 2'd0,
    MODE_BB    = 2'd1,
    MODE_BOOST = 2'd2
  } opMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic routeHs;
    logic routeLs;
    logic slewing;
    logic gateOpen;
  } swStrobe_t;
endpackage

// File: rtl/est_switch_ctrl_fsm.sv
module est_switch_ctrl_fsm import est_switch_pkg::*; #(
  parameter int CNT_W    = 4,
  parameter int DEF_SLEW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opMode,
  input  logic             buckDrv,
  input  logic             boostDrv,
  input  logic             hsSense,
  input  logic             hsSettled,
  input  logic             slewLoad,
  input  logic [CNT_W-1:0] slewLenIn,
  output swStrobe_t        strobe
);
  localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(DEF_SLEW);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             buckPrev;
  logic             slewReg;
  logic [CNT_W-1:0] slewCnt;
  logic [CNT_W-1:0] slewLenReg;
  logic             riseNow;
  logic             slewActive;

  assign riseNow    = buckDrv & ~buckPrev;
  assign slewActive = (riseNow | slewReg) & ~hsSettled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slewLenReg <= DEF_LEN;
    end else if (slewLoad) begin
      slewLenReg <= slewLenIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      buckPrev <= 1'b0;
      slewReg  <= 1'b0;
      slewCnt  <= '0;
    end else begin
      buckPrev <= buckDrv;
      if (riseNow) begin
        slewCnt <= ONE;
        slewReg <= (slewLenReg > ONE) && !hsSettled;
      end else if (slewReg) begin
        if (hsSettled || slewCnt >= slewLenReg - ONE) begin
          slewReg <= 1'b0;
        end else begin
          slewCnt <= slewCnt + ONE;
        end
      end
    end
  end

  always_comb begin
    strobe.slewing  = slewActive;
    strobe.routeHs  = buckDrv & hsSense & ~slewActive;
    strobe.routeLs  = ~buckDrv | slewActive;
    strobe.gateOpen = (opMode == MODE_BUCK) | ~boostDrv;
  end

  // R7
  slew_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    slewReg |-> (slewCnt != '0));

  // R11
  settle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slewReg && hsSettled) |=> !slewReg || riseNow);
endmodule

// File: rtl/est_switch_datapath.sv
module est_switch_datapath import est_switch_pkg::*; #(
  parameter int N_SW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  swStrobe_t       strobe,
  output logic [N_SW-1:0] swEn
);
  logic [N_SW-1:0] swNext;
  logic            anyRoute;

  assign anyRoute = strobe.routeHs | strobe.routeLs;

  always_comb begin
    swNext    = '0;
    swNext[0] = ~strobe.routeLs;              // S1 low-side aux
    swNext[1] = strobe.routeLs;               // S2 low-side route
    swNext[2] = strobe.routeHs;               // S3 high-side route
    swNext[3] = strobe.slewing;               // S4 high-side dummy
    swNext[4] = ~strobe.routeLs;              // S5 low-side aux
    swNext[5] = anyRoute & ~strobe.gateOpen;  // S6 shunt
    swNext[6] = anyRoute & strobe.gateOpen;   // S7 resistor gate
    swNext[7] = strobe.slewing;               // S8 high-side dummy
  end

  always_ff @(posedge clk) begin
    if (!rstN) swEn <= '0;
    else       swEn <= swNext;
  end

  // R9
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(swEn[2] && swEn[3]));

  // R9
  ls_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(swEn[1] && swEn[0]));

  // R5
  gate_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gateOpen |=> !swEn[6]);

  // R7
  dummy_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    swEn[3] == swEn[7]);

  // R8
  aux_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    swEn[0] == swEn[4]);
endmodule

// File: rtl/est_switch_ctrl.sv
module est_switch_ctrl import est_switch_pkg::*; #(
  parameter int CNT_W    = 4,
  parameter int DEF_SLEW = 4,
  parameter int N_SW     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opMode,
  input  logic             buckDrv,
  input  logic             boostDrv,
  input  logic             hsSense,
  input  logic             hsSettled,
  input  logic             slewLoad,
  input  logic [CNT_W-1:0] slewLenIn,
  output logic [N_SW-1:0]  swEn
);
  swStrobe_t strobe;

  est_switch_ctrl_fsm #(.CNT_W(CNT_W), .DEF_SLEW(DEF_SLEW)) u_fsm (
    .clk(clk), .rstN(rstN), .opMode(opMode), .buckDrv(buckDrv),
    .boostDrv(boostDrv), .hsSense(hsSense), .hsSettled(hsSettled),
    .slewLoad(slewLoad), .slewLenIn(slewLenIn), .strobe(strobe)
  );

  est_switch_datapath #(.N_SW(N_SW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swEn(swEn)
  );

  // R1
  reset_open_chk: assert property (@(posedge clk)
    !rstN |=> (swEn == '0) || rstN);
endmodule

// File: tb/est_switch_ctrl_bench.sv
module est_switch_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic       buckDrv = 1'b0, boostDrv = 1'b0, hsSense = 1'b0;
  logic       hsSettled = 1'b0, slewLoad = 1'b0;
  logic [3:0] slewLenIn = 4'd0;
  logic [7:0] swEn;
  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  est_switch_ctrl u_est_switch_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .buckDrv(buckDrv),
    .boostDrv(boostDrv), .hsSense(hsSense), .hsSettled(hsSettled),
    .slewLoad(slewLoad), .slewLenIn(slewLenIn), .swEn(swEn)
  );

  function automatic logic [7:0] expSw(input logic hs, input logic ls,
                                       input logic slew, input logic gate);
    logic [7:0] v;
    v[0] = ~ls;  v[1] = ls;  v[2] = hs;  v[3] = slew;
    v[4] = ~ls;  v[5] = (hs | ls) & ~gate;
    v[6] = (hs | ls) & gate;  v[7] = slew;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    vectors++;
    if (swEn !== exp) begin
      fails++;
      $display("FAIL %s: swEn=%b expected %b", req, swEn, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(input logic [1:0] m, input logic bk,
                      input logic bo, input logic hs);
    opMode = m; buckDrv = bk; boostDrv = bo; hsSense = hs;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    check("R1 reset", 8'h00);
    rstN = 1'b1;
  endtask

  task automatic t_buck();
    step(2'd0, 1'b0, 1'b0, 1'b0);
    check("R4 buck low-side", expSw(0, 1, 0, 1));
    for (int i = 0; i < 4; i++) begin
      step(2'd0, 1'b1, 1'b0, 1'b1);
      check("R7 slew window", expSw(0, 1, 1, 1));
    end
    step(2'd0, 1'b1, 1'b0, 1'b1);
    check("R3 high-side routed", expSw(1, 0, 0, 1));
    step(2'd0, 1'b1, 1'b0, 1'b0);
    check("R8 no route", expSw(0, 0, 0, 1));
  endtask

  task automatic t_buck_ignores_boost();
    step(2'd0, 1'b1, 1'b1, 1'b1);
    check("R5 buck ignores boost", expSw(1, 0, 0, 1));
  endtask

  task automatic t_bb_gate();
    step(2'd1, 1'b0, 1'b1, 1'b0);
    check("R6 bb gate shut", expSw(0, 1, 0, 0));
    step(2'd1, 1'b0, 1'b0, 1'b0);
    check("R5 bb gate open", expSw(0, 1, 0, 1));
  endtask

  task automatic t_boost();
    step(2'd0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(2'd0, 1'b1, 1'b0, 1'b1);
    step(2'd2, 1'b1, 1'b1, 1'b1);
    check("R6 boost shut", expSw(1, 0, 0, 0));
    step(2'd2, 1'b1, 1'b0, 1'b1);
    check("R5 boost open", expSw(1, 0, 0, 1));
  endtask

  task automatic t_prog_len();
    slewLenIn = 4'd2; slewLoad = 1'b1;
    step(2'd0, 1'b0, 1'b0, 1'b1);
    slewLoad = 1'b0;
    step(2'd0, 1'b0, 1'b0, 1'b1);
    step(2'd0, 1'b1, 1'b0, 1'b1);
    check("R10 slew cycle 1", expSw(0, 1, 1, 1));
    step(2'd0, 1'b1, 1'b0, 1'b1);
    check("R10 slew cycle 2", expSw(0, 1, 1, 1));
    step(2'd0, 1'b1, 1'b0, 1'b1);
    check("R10 slew over", expSw(1, 0, 0, 1));
  endtask

  task automatic t_settle();
    slewLenIn = 4'd8; slewLoad = 1'b1;
    step(2'd0, 1'b0, 1'b0, 1'b1);
    slewLoad = 1'b0;
    step(2'd1, 1'b1, 1'b0, 1'b1);
    check("R7 bb slew", expSw(0, 1, 1, 1));
    hsSettled = 1'b1;
    step(2'd1, 1'b1, 1'b0, 1'b1);
    check("R11 settled ends", expSw(1, 0, 0, 1));
    hsSettled = 1'b0;
    step(2'd1, 1'b1, 1'b0, 1'b1);
    check("R11 stays ended", expSw(1, 0, 0, 1));
  endtask

  task automatic t_registered();
    opMode = 2'd0; buckDrv = 1'b0; boostDrv = 1'b0; hsSense = 1'b0;
    @(posedge clk); #2;
    check("R2 updates at edge", expSw(0, 1, 0, 1));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_buck();
        t_buck_ignores_boost();
        t_bb_gate();
        t_boost();
        t_prog_len();
        t_settle();
        t_registered();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule